// File: doc/BRIEF.md
# UART Host Register Bank with Interrupt Identification

This block is the processor-facing half of a classic byte-wide serial controller. A host reaches eight byte locations through a 3-bit offset, a read strobe and a write strobe. Behind them sit the interrupt enables, line and modem control, a scratch byte and a 16-bit baud divisor. A line-control bit moves the divisor bytes over offsets 0 and 1.

The receiver, transmitter, FIFOs and modem pins live elsewhere. They appear here only as level status, one-cycle event pulses and pop, push and flush strobes. The block assembles a line-status byte from that status. It keeps four interrupt sources, ranks them and reports the winner as an identification code. It drives a single interrupt line.

Each source is cleared as a side effect of the host access that services it. When a set and a clear for the same item fall in the same cycle, the set wins.

Top module: `uart_regfile`

## Requirements
- R1: With line-control bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes (`baud_div`). A write to offset 0 then produces no `tx_push`. With bit 7 clear, offset 0 writes push `bus_wdata` out on `tx_byte` with a one-cycle `tx_push`, and offset 1 is the interrupt enable.
- R2: The interrupt enable (offset 1, low 4 bits kept), line control (offset 3, 8 bits), modem control (offset 4, low 5 bits kept) and scratch (offset 7) read back what was written, with unkept bits reading 0. After reset all of them read 0.
- R3: Offset 5 reads the line-status byte. Its bits are:
  - bit 0: receive data ready
  - bit 1: overrun
  - bit 2: parity error
  - bit 3: framing error
  - bit 4: break
  - bit 5: `tx_room`
  - bit 6: `tx_room` AND `tx_idle`
  - bit 7: `rx_fifo_bad`
- R4: Bits 1 to 4 of the line-status byte are sticky. They are set by their event pulse and cleared in the cycle after a read of offset 5.
- R5: Offset 2 reads the identification byte. Bit 0 is 0 when any enabled source is pending and 1 otherwise. Bits [3:1] name the highest-ranked enabled pending source: 011 line status, 010 received data, 001 holding empty, 000 modem status, ranked in that order. A source whose enable bit is 0 is never reported.
- R6: A write to offset 2 stores bit 0 as the FIFO enable, which makes identification bits [7:6] read 11. Bits 1 and 2 of the same write give one-cycle `rx_flush` and `tx_flush` pulses.
- R7: The received-data source is pending while `rx_ready` is high. The holding-empty source is set by a rising edge of `tx_room`. It clears on a write to offset 0 with bit 7 clear, or on an identification read that reports it.
- R8: The modem source is set by `modem_evt` and cleared by a read of offset 6. That read returns `modem_stat`.
- R9: `irq` is high only when some enabled source is pending and modem-control bit 3 is 1.
- R10: An event that sets a line-status bit or the holding-empty source in the same cycle as the access that would clear it leaves that bit or source set.
- R11: A read of offset 0 with bit 7 clear returns `rx_byte` and gives a one-cycle `rx_pop`. No other access pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` |
| rx_byte | input | 8 | Byte at the head of the receive FIFO |
| rx_ready | input | 1 | Receive FIFO holds data |
| rx_fifo_bad | input | 1 | Receive FIFO holds a byte with an error |
| err_overrun | input | 1 | Overrun event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_frame | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break event pulse |
| tx_room | input | 1 | Transmit holding stage empty |
| tx_idle | input | 1 | Transmit shifter idle |
| modem_stat | input | 8 | Modem status byte |
| modem_evt | input | 1 | Modem status change pulse |
| rx_pop | output | 1 | Pop the receive FIFO |
| tx_push | output | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | output | 8 | Byte to transmit |
| rx_flush | output | 1 | Clear the receive FIFO |
| tx_flush | output | 1 | Clear the transmit FIFO |
| line_cfg | output | 8 | Line-control register |
| modem_ctl | output | 5 | Modem-control register |
| baud_div | output | 16 | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can collide in one cycle.

The first pair is the sticky error capture and the clearing line-status read. The bench raises the parity pulse inside the same strobe window as a read of offset 5. That read must return the old byte, and the following read must still show bit 2 together with a raised `irq`.

The second pair is the holding-empty edge detector and the clearing transmit write. The bench raises `tx_room` in the same window as an offset-0 write. The source must remain pending and be reported as code 001.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int SRC_N  = 4;
    localparam int ERR_N  = 4;
    localparam int MCR_W  = 5;

    // source index equals interrupt enable bit position
    localparam int SRC_RDA  = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_LS   = 2;
    localparam int SRC_MS   = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DATA  = 3'd0,
        OFF_IEN   = 3'd1,
        OFF_IDENT = 3'd2,
        OFF_LCTL  = 3'd3,
        OFF_MCTL  = 3'd4,
        OFF_LSTAT = 3'd5,
        OFF_MSTAT = 3'd6,
        OFF_SCR   = 3'd7
    } reg_off_e;

    typedef enum logic [2:0] {
        ID_MS   = 3'b000,
        ID_THRE = 3'b001,
        ID_RDA  = 3'b010,
        ID_LS   = 3'b011
    } int_id_e;

    typedef struct packed {
        logic rbr_rd;
        logic thr_wr;
        logic dll_wr;
        logic dlm_wr;
        logic ier_wr;
        logic iir_rd;
        logic fcr_wr;
        logic lcr_wr;
        logic mcr_wr;
        logic lsr_rd;
        logic msr_rd;
        logic scr_wr;
    } acc_s;

    typedef struct packed {
        logic [SRC_N-1:0]  ier;
        logic [DATA_W-1:0] lcr;
        logic [MCR_W-1:0]  mcr;
        logic [DATA_W-1:0] scr;
        logic [DIV_W-1:0]  div;
        logic              fifo_en;
        logic [ERR_N-1:0]  err;      // {break, frame, parity, overrun}
        logic              thre_pend;
        logic              ms_pend;
        logic              thr_prev;
    } state_s;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              dlab,
    output acc_s              acc
);
    reg_off_e off;

    always_comb begin
        off = reg_off_e'(addr);
        acc = '0;
        unique case (off)
            OFF_DATA: begin
                acc.rbr_rd = rd & ~dlab;
                acc.thr_wr = wr & ~dlab;
                acc.dll_wr = wr & dlab;
            end
            OFF_IEN: begin
                acc.ier_wr = wr & ~dlab;
                acc.dlm_wr = wr & dlab;
            end
            OFF_IDENT: begin
                acc.iir_rd = rd;
                acc.fcr_wr = wr;
            end
            OFF_LCTL:  acc.lcr_wr = wr;
            OFF_MCTL:  acc.mcr_wr = wr;
            OFF_LSTAT: acc.lsr_rd = rd;
            OFF_MSTAT: acc.msr_rd = rd;
            OFF_SCR:   acc.scr_wr = wr;
            default:   acc = '0;
        endcase
    end
endmodule

// File: rtl/uart_rf_intr.sv
module uart_rf_intr
    import uart_rf_pkg::*;
(
    input  logic [SRC_N-1:0]  pend,
    input  logic [SRC_N-1:0]  ien,
    input  logic              fifo_en,
    input  logic              out2,
    output logic [DATA_W-1:0] iir,
    output logic              thre_shown,
    output logic              irq
);
    logic [SRC_N-1:0] act;
    int_id_e          id;
    logic             any;

    for (genvar g = 0; g < SRC_N; g++) begin : g_mask
        assign act[g] = pend[g] & ien[g];
    end

    always_comb begin
        any        = |act;
        thre_shown = 1'b0;
        if (act[SRC_LS])        id = ID_LS;
        else if (act[SRC_RDA])  id = ID_RDA;
        else if (act[SRC_THRE]) begin
            id         = ID_THRE;
            thre_shown = 1'b1;
        end
        else                    id = ID_MS;
        iir = {{2{fifo_en}}, 2'b00, id, ~any};
        irq = any & out2;
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter logic [15:0] DIV_RESET = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        rx_byte,
    input  logic              rx_ready,
    input  logic              rx_fifo_bad,
    input  logic              err_overrun,
    input  logic              err_parity,
    input  logic              err_frame,
    input  logic              err_break,
    input  logic              tx_room,
    input  logic              tx_idle,
    input  logic [7:0]        modem_stat,
    input  logic              modem_evt,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic [7:0]        line_cfg,
    output logic [4:0]        modem_ctl,
    output logic [15:0]       baud_div,
    output logic              irq
);
    localparam int DLAB_BIT = DATA_W - 1;
    localparam int OUT2_BIT = 3;

    state_s            st_q, st_d;
    acc_s              acc;
    logic [DATA_W-1:0] iir_w;
    logic [DATA_W-1:0] lsr_w;
    logic [SRC_N-1:0]  pend_w;
    logic [ERR_N-1:0]  err_evt;
    logic              thre_shown;
    logic              thre_rise;

    uart_rf_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .dlab (st_q.lcr[DLAB_BIT]),
        .acc  (acc)
    );

    always_comb begin
        pend_w           = '0;
        pend_w[SRC_RDA]  = rx_ready;
        pend_w[SRC_THRE] = st_q.thre_pend;
        pend_w[SRC_LS]   = |st_q.err;
        pend_w[SRC_MS]   = st_q.ms_pend;
    end

    uart_rf_intr u_intr (
        .pend       (pend_w),
        .ien        (st_q.ier),
        .fifo_en    (st_q.fifo_en),
        .out2       (st_q.mcr[OUT2_BIT]),
        .iir        (iir_w),
        .thre_shown (thre_shown),
        .irq        (irq)
    );

    assign err_evt   = {err_break, err_frame, err_parity, err_overrun};
    assign thre_rise = tx_room & ~st_q.thr_prev;
    assign lsr_w     = {rx_fifo_bad, tx_room & tx_idle, tx_room, st_q.err, rx_ready};

    // read mux
    always_comb begin
        unique case (reg_off_e'(bus_addr))
            OFF_DATA:  bus_rdata = st_q.lcr[DLAB_BIT] ? st_q.div[7:0] : rx_byte;
            OFF_IEN:   bus_rdata = st_q.lcr[DLAB_BIT] ? st_q.div[15:8]
                                                      : {{(DATA_W-SRC_N){1'b0}}, st_q.ier};
            OFF_IDENT: bus_rdata = iir_w;
            OFF_LCTL:  bus_rdata = st_q.lcr;
            OFF_MCTL:  bus_rdata = {{(DATA_W-MCR_W){1'b0}}, st_q.mcr};
            OFF_LSTAT: bus_rdata = lsr_w;
            OFF_MSTAT: bus_rdata = modem_stat;
            OFF_SCR:   bus_rdata = st_q.scr;
            default:   bus_rdata = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (acc.ier_wr) st_d.ier      = bus_wdata[SRC_N-1:0];
        if (acc.lcr_wr) st_d.lcr      = bus_wdata;
        if (acc.mcr_wr) st_d.mcr      = bus_wdata[MCR_W-1:0];
        if (acc.scr_wr) st_d.scr      = bus_wdata;
        if (acc.dll_wr) st_d.div[7:0] = bus_wdata;
        if (acc.dlm_wr) st_d.div[15:8] = bus_wdata;
        if (acc.fcr_wr) st_d.fifo_en  = bus_wdata[0];

        // sticky errors: clear after read, new events win
        if (acc.lsr_rd) st_d.err = '0;
        st_d.err = st_d.err | err_evt;

        // holding-empty source
        st_d.thr_prev = tx_room;
        if (acc.thr_wr || (acc.iir_rd && thre_shown)) st_d.thre_pend = 1'b0;
        if (thre_rise) st_d.thre_pend = 1'b1;

        // modem source
        if (acc.msr_rd) st_d.ms_pend = 1'b0;
        if (modem_evt)  st_d.ms_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.div      <= DIV_RESET;
            st_q.thr_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_pop    = acc.rbr_rd;
    assign tx_push   = acc.thr_wr;
    assign tx_byte   = bus_wdata;
    assign rx_flush  = acc.fcr_wr & bus_wdata[1];
    assign tx_flush  = acc.fcr_wr & bus_wdata[2];
    assign line_cfg  = st_q.lcr;
    assign modem_ctl = st_q.mcr;
    assign baud_div  = st_q.div;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
    import uart_rf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] line_cfg,
    input logic [4:0] modem_ctl,
    input logic       irq,
    input logic       tx_push,
    input logic       rx_pop,
    input logic       tx_room,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_break,
    input logic       modem_evt,
    input logic [7:0] iir,
    input state_s     st
);
    logic any_err;
    assign any_err = err_overrun | err_parity | err_frame | err_break;

    p_dlab_no_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && line_cfg[7]) |-> !tx_push);

    p_lsr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5 && !any_err) |=> (st.err == '0));

    p_pend_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !iir[0]);

    p_thr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !(tx_room && !st.thr_prev)) |=> !st.thre_pend);

    p_ms_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd6 && !modem_evt) |=> !st.ms_pend);

    p_out2_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_ctl[3] |-> !irq);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |=> st.err[1]);

    p_pop_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_rd && bus_addr == 3'd0 && !line_cfg[7]));
endmodule

bind uart_regfile uart_regfile_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .line_cfg    (line_cfg),
    .modem_ctl   (modem_ctl),
    .irq         (irq),
    .tx_push     (tx_push),
    .rx_pop      (rx_pop),
    .tx_room     (tx_room),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break),
    .modem_evt   (modem_evt),
    .iir         (iir_w),
    .st          (st_q)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] rx_byte = 8'h3C;
    logic       rx_ready = 1'b0, rx_fifo_bad = 1'b0;
    logic       err_overrun = 1'b0, err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
    logic       tx_room = 1'b1, tx_idle = 1'b1;
    logic [7:0] modem_stat = 8'hA5;
    logic       modem_evt = 1'b0;
    logic       rx_pop, tx_push, rx_flush, tx_flush, irq;
    logic [7:0] tx_byte, line_cfg;
    logic [4:0] modem_ctl;
    logic [15:0] baud_div;

    int tests = 0, fails = 0;
    int push_cnt = 0, pop_cnt = 0, rfl_cnt = 0, tfl_cnt = 0;
    logic [7:0] last_push = '0;
    logic [7:0] v;

    always #5 clk = ~clk;

    uart_regfile dut_i (.*);

    always @(posedge clk) begin
        if (tx_push) begin push_cnt++; last_push <= tx_byte; end
        if (rx_pop) pop_cnt++;
        if (rx_flush) rfl_cnt++;
        if (tx_flush) tfl_cnt++;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic modem_pulse();
        @(negedge clk); modem_evt = 1'b1;
        @(negedge clk); modem_evt = 1'b0;
    endtask

    task automatic room_edge();
        @(negedge clk); tx_room = 1'b0;
        @(negedge clk); tx_room = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd(3'd1, v); chk("R2 ien reset", v, 8'h00);
        rd(3'd3, v); chk("R2 lcr reset", v, 8'h00);
        rd(3'd4, v); chk("R2 mcr reset", v, 8'h00);
        rd(3'd7, v); chk("R2 scr reset", v, 8'h00);
        rd(3'd2, v); chk("R5 iir reset", v, 8'h01);
        rd(3'd5, v); chk("R3 lsr reset", v, 8'h60);
        chk("R9 irq reset", irq, 0);
    endtask

    task automatic t_regs();
        wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 ien mask", v, 8'h0F);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk("R2 mcr mask", v, 8'h1F);
        wr(3'd7, 8'hA5); rd(3'd7, v); chk("R2 scr", v, 8'hA5);
        wr(3'd3, 8'h1B); rd(3'd3, v); chk("R2 lcr", v, 8'h1B);
        wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd3, 8'h00);
    endtask

    task automatic t_dlab();
        int p0;
        p0 = push_cnt;
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        chk("R1 divisor", baud_div, 16'h1234);
        chk("R1 no push under dlab", push_cnt, p0);
        rd(3'd0, v); chk("R1 divisor low read", v, 8'h34);
        chk("R11 no pop under dlab", pop_cnt, 0);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h05); rd(3'd1, v); chk("R1 ien at offset 1", v, 8'h05);
        chk("R1 divisor kept", baud_div, 16'h1234);
        wr(3'd0, 8'h5A);
        chk("R1 push count", push_cnt, p0 + 1);
        chk("R1 push byte", last_push, 8'h5A);
        rd(3'd0, v); chk("R11 rx byte", v, 8'h3C);
        chk("R11 pop count", pop_cnt, 1);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_lsr();
        rx_ready = 1'b1; rx_fifo_bad = 1'b1;
        @(negedge clk); err_overrun = 1'b1;
        @(negedge clk); err_overrun = 1'b0; err_frame = 1'b1;
        @(negedge clk); err_frame = 1'b0;
        rd(3'd5, v); chk("R3 lsr layout", v, 8'hEB);
        rd(3'd5, v); chk("R4 lsr sticky cleared", v, 8'hE1);
        rx_ready = 1'b0; rx_fifo_bad = 1'b0;
    endtask

    task automatic t_iir();
        wr(3'd1, 8'h0F); wr(3'd4, 8'h08);
        rd(3'd2, v); chk("R5 idle", v, 8'h01);
        modem_pulse();
        rd(3'd2, v); chk("R8 modem code", v, 8'h00);
        chk("R9 irq on", irq, 1);
        @(negedge clk); rx_ready = 1'b1;
        rd(3'd2, v); chk("R5 rda over modem", v, 8'h04);
        room_edge();
        rd(3'd2, v); chk("R5 rda over thre", v, 8'h04);
        @(negedge clk); err_parity = 1'b1;
        @(negedge clk); err_parity = 1'b0;
        rd(3'd2, v); chk("R5 ls highest", v, 8'h06);
        rd(3'd5, v); chk("R3 lsr parity", v, 8'h65);
        rd(3'd2, v); chk("R4 ls cleared", v, 8'h04);
        @(negedge clk); rx_ready = 1'b0;
        rd(3'd2, v); chk("R7 thre code", v, 8'h02);
        rd(3'd2, v); chk("R7 thre cleared by ident read", v, 8'h00);
        rd(3'd6, v); chk("R8 modem stat value", v, 8'hA5);
        rd(3'd2, v); chk("R8 modem cleared", v, 8'h01);
        chk("R9 irq off", irq, 0);
    endtask

    task automatic t_out2();
        wr(3'd4, 8'h00);
        modem_pulse();
        chk("R9 out2 gates irq", irq, 0);
        rd(3'd2, v); chk("R9 pending without irq", v, 8'h00);
        rd(3'd6, v);
    endtask

    task automatic t_thre_wr();
        wr(3'd1, 8'h02); wr(3'd4, 8'h08);
        room_edge();
        chk("R7 thre irq", irq, 1);
        wr(3'd0, 8'h11);
        chk("R7 thr write clears", irq, 0);
        rd(3'd2, v); chk("R7 idle after write", v, 8'h01);
    endtask

    task automatic t_mask();
        wr(3'd1, 8'h00);
        modem_pulse();
        rd(3'd2, v); chk("R5 disabled source hidden", v, 8'h01);
        chk("R5 disabled no irq", irq, 0);
        rd(3'd6, v);
    endtask

    task automatic t_fifo();
        wr(3'd2, 8'h07);
        chk("R6 rx flush", rfl_cnt, 1);
        chk("R6 tx flush", tfl_cnt, 1);
        rd(3'd2, v); chk("R6 fifo bits", v, 8'hC1);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R6 fifo off", v, 8'h01);
        chk("R6 no extra flush", rfl_cnt + tfl_cnt, 2);
    endtask

    task automatic t_same();
        wr(3'd1, 8'h04);
        @(negedge clk);
        bus_addr = 3'd5; bus_rd = 1'b1; err_parity = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; err_parity = 1'b0;
        chk("R10 read shows old", v, 8'h60);
        chk("R10 ls irq kept", irq, 1);
        rd(3'd5, v); chk("R10 parity kept", v, 8'h64);
        wr(3'd1, 8'h02);
        @(negedge clk); tx_room = 1'b0;
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h22; bus_wr = 1'b1; tx_room = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 thre kept", irq, 1);
        rd(3'd2, v); chk("R10 thre code", v, 8'h02);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_dlab();
        t_lsr();
        t_iir();
        t_out2();
        t_thre_wr();
        t_mask();
        t_fifo();
        t_same();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule